// File: doc/BRIEF.md
# Inverter Output High-Impedance Shutdown Controller

This block watches two fault sources beside a PWM timer that drives six gate outputs. When a source goes active it forces a group of those outputs into high impedance. Each fault source is either an external shutoff input or an internal comparator output. The controller then releases the outputs, but only on a PWM period boundary, and only after the fault has cleared or software has asked for release.

A 16-bit mode register sets the behaviour. Bit 15 picks the output grouping: six-phase (all six outputs) or split half-bridge (two pairs). Bit 14 picks the fault source. Bit 13 sets the release method in half-bridge mode. Bit 12 sets the release method in six-phase mode. Bits 11 to 0 are only stored. The register can be written only while the Hi-Z enable field is zero and both master period channels are stopped. Output mask bit k stands for timer output k+2, so bit 0 is output 2 and bit 5 is output 7.

The fault inputs pass through a two-flop synchronizer and then an edge detector. Period pulses and cancel strobes are single-cycle, active-high pulses in the block clock domain.

Top module: `hiz_shutdown_ctrl`

## Requirements
- R1: After reset, the mode readback is 0x0000, the Hi-Z mask is 000000 and the fault flag is 0.
- R2: A mode write is ignored unless the Hi-Z enable field is 00 and both master run inputs are 0.
- R3: In six-phase mode (bit 15 = 0), any latched fault drives all six mask bits to 1 and raises the fault flag.
- R4: In half-bridge mode (bit 15 = 1), source 0 drives mask bits 1:0 and source 1 drives mask bits 5:4. Mask bits 3:2 stay 0.
- R5: With bit 14 = 0 the fault sources are the external shutoff inputs. With bit 14 = 1 they are the comparator outputs, and the unselected inputs have no effect.
- R6: In six-phase mode with bit 12 = 0, source 0 releases automatically after its inactive edge. Source 1 releases only after a software cancel strobe.
- R7: In six-phase mode with bit 12 = 1, source 0 is active low and source 1 is active high. Both release automatically after their inactive edge.
- R8: In half-bridge mode, bit 13 = 0 gives automatic release after the inactive edge. Bit 13 = 1 gives release only after a software cancel strobe.
- R9: Hi-Z is set by an active edge, not by a level. A source held active after its release does not set Hi-Z again.
- R10: Release happens only on a period pulse that comes in a later cycle than the arming event. A source that has gone inactive but has seen no period pulse keeps its outputs in Hi-Z.
- R11: An armed release is discarded if the same source becomes active again before the period pulse.
- R12: While the enable field is 00, the mask is 000000 and all latched fault state is cleared. It stays clear when the field is set nonzero again.
- R13: Mode bits 11:0 read back as written and change no output behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_off_i | input | 2 | External shutoff inputs, active high, asynchronous |
| cmp_i | input | 2 | Internal comparator outputs, asynchronous |
| period_pulse_i | input | 1 | One-cycle PWM period boundary pulse |
| sw_cancel_i | input | 1 | One-cycle software cancel strobe |
| chan_run_i | input | 2 | Run status of master channels 0 (bit 0) and 4 (bit 1) |
| hiz_en_i | input | 2 | Hi-Z enable field; 00 disables |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 16 | Mode register write data |
| mode_q_o | output | 16 | Mode register readback |
| hiz_mask_o | output | 6 | Per-output Hi-Z mask, bit k is output k+2 |
| fault_o | output | 1 | High while any fault is latched |

## Verification
The bench probes the release window. A design that releases as soon as the inactive edge arrives, without waiting for the period pulse, clears the mask one check too early. It also drives a source that goes active again before the boundary. A design that keeps the armed release then drops Hi-Z while the fault is still present. The bench keeps the second six-phase source high after a software release, so a design that sets Hi-Z on level instead of edge would latch again at once. Further checks cover the swapped polarity in back-EMF mode, the split mask groups, and writes attempted while a channel runs. A design with a mux or gating error in any of these shows a wrong mask or readback.

// File: rtl/hiz_pkg.sv
// Package: shared constants and mode decode for the Hi-Z shutdown controller.
// Assumes a 16-bit mode word with control bits in the top nibble.
package hiz_pkg;
    localparam int unsigned MODE_W       = 16;
    localparam int unsigned NUM_SRC      = 2;
    localparam int unsigned NUM_OUT      = 6;
    localparam int unsigned BIT_GROUPING = 15;
    localparam int unsigned BIT_SRC_SEL  = 14;
    localparam int unsigned BIT_HB_SW    = 13;
    localparam int unsigned BIT_SIX_BEMF = 12;

    typedef struct packed {
        logic half_bridge;
        logic use_cmp;
        logic hb_sw_release;
        logic six_bemf;
    } mode_ctl_t;

    function automatic mode_ctl_t decode_mode(input logic [MODE_W-1:0] m);
        mode_ctl_t c;
        c.half_bridge   = m[BIT_GROUPING];
        c.use_cmp       = m[BIT_SRC_SEL];
        c.hb_sw_release = m[BIT_HB_SW];
        c.six_bemf      = m[BIT_SIX_BEMF];
        return c;
    endfunction
endpackage

// File: rtl/hiz_mode_reg.sv
// Module: mode register with a guarded write.
// Assumes the enable field and run status are already in the clock domain.
module hiz_mode_reg #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic [1:0]   hiz_en_i,
    input  logic [1:0]   chan_run_i,
    output logic [W-1:0] q_o
);
    logic wr_ok;
    assign wr_ok = wr_i && (hiz_en_i == 2'b00) && (chan_run_i == 2'b00);

    // Purpose: capture write data only when output control is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= '0;
        else if (wr_ok) q_o <= wdata_i;
    end

    a_r2_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (hiz_en_i != 2'b00 || chan_run_i != 2'b00)) |=> $stable(q_o));
endmodule

// File: rtl/hiz_fault_input.sv
// Module: one fault channel - synchronizes both candidate inputs, selects
// one, applies the polarity, and detects active/inactive edges.
// Assumes SYNC_STAGES >= 2; the inputs are asynchronous levels.
module hiz_fault_input #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_i,
    input  logic cmp_i,
    input  logic use_cmp_i,
    input  logic invert_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned MSB = SYNC_STAGES - 1;

    logic [MSB:0] ext_sync;
    logic [MSB:0] cmp_sync;
    logic         active;
    logic         active_q;

    // Purpose: multi-flop synchronizers for both raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_sync <= '0;
            cmp_sync <= '0;
        end else begin
            ext_sync <= {ext_sync[MSB-1:0], ext_i};
            cmp_sync <= {cmp_sync[MSB-1:0], cmp_i};
        end
    end

    assign active = (use_cmp_i ? cmp_sync[MSB] : ext_sync[MSB]) ^ invert_i;

    // Purpose: delayed copy of the active level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    assign rise_o = active & ~active_q;
    assign fall_o = ~active & active_q;
endmodule

// File: rtl/hiz_src_latch.sv
// Module: per-source fault latch with a release armed by the inactive edge
// or a cancel strobe, then taken on a later period pulse.
// Assumes rise/fall are one-cycle pulses from the edge detector.
module hiz_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic sw_cancel_i,
    input  logic period_i,
    input  logic auto_rel_i,
    output logic latched_o
);
    logic pending;
    logic arm;

    assign arm = auto_rel_i ? fall_i : sw_cancel_i;

    // Purpose: set on active edge, arm release, release on period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            latched_o <= 1'b0;
            pending   <= 1'b0;
        end else if (rise_i) begin
            latched_o <= 1'b1;
            pending   <= 1'b0;
        end else if (latched_o) begin
            if (pending && period_i) begin
                latched_o <= 1'b0;
                pending   <= 1'b0;
            end else if (arm) begin
                pending   <= 1'b1;
            end
        end
    end

    a_r9_set_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latched_o) |-> $past(rise_i));
    a_r10_release_on_period: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latched_o) |-> ($past(period_i) || !$past(enable_i)));
endmodule

// File: rtl/hiz_shutdown_ctrl.sv
// Module: top of the Hi-Z shutdown controller. Decodes the mode, runs two
// fault channels, and maps the latched faults onto the six-output mask.
// Assumes period and cancel inputs are one-cycle pulses in clk's domain.
module hiz_shutdown_ctrl #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 ext_off_i,
    input  logic [1:0]                 cmp_i,
    input  logic                       period_pulse_i,
    input  logic                       sw_cancel_i,
    input  logic [1:0]                 chan_run_i,
    input  logic [1:0]                 hiz_en_i,
    input  logic                       mode_wr_i,
    input  logic [15:0]                mode_wdata_i,
    output logic [15:0]                mode_q_o,
    output logic [5:0]                 hiz_mask_o,
    output logic                       fault_o
);
    import hiz_pkg::*;

    mode_ctl_t          ctl;
    logic               enable;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;
    logic [NUM_SRC-1:0] latched;
    logic [NUM_SRC-1:0] auto_rel;
    logic [NUM_SRC-1:0] invert;
    logic [NUM_OUT-1:0] six_mask;
    logic [NUM_OUT-1:0] half_mask;

    hiz_mode_reg #(.W(MODE_W)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (mode_wr_i),
        .wdata_i    (mode_wdata_i),
        .hiz_en_i   (hiz_en_i),
        .chan_run_i (chan_run_i),
        .q_o        (mode_q_o)
    );

    assign ctl    = decode_mode(mode_q_o);
    assign enable = (hiz_en_i != 2'b00);

    // Per-source release policy and polarity.
    assign auto_rel[0] = ctl.half_bridge ? ~ctl.hb_sw_release : 1'b1;
    assign auto_rel[1] = ctl.half_bridge ? ~ctl.hb_sw_release : ctl.six_bemf;
    assign invert[0]   = ~ctl.half_bridge & ctl.six_bemf;
    assign invert[1]   = 1'b0;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hiz_fault_input #(.SYNC_STAGES(SYNC_STAGES)) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .ext_i     (ext_off_i[s]),
            .cmp_i     (cmp_i[s]),
            .use_cmp_i (ctl.use_cmp),
            .invert_i  (invert[s]),
            .rise_o    (rise[s]),
            .fall_o    (fall[s])
        );

        hiz_src_latch u_latch (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable_i    (enable),
            .rise_i      (rise[s]),
            .fall_i      (fall[s]),
            .sw_cancel_i (sw_cancel_i),
            .period_i    (period_pulse_i),
            .auto_rel_i  (auto_rel[s]),
            .latched_o   (latched[s])
        );
    end

    assign six_mask  = {NUM_OUT{|latched}};
    assign half_mask = {latched[1], latched[1], 2'b00, latched[0], latched[0]};

    // Purpose: choose the output grouping and gate by the enable field.
    always_comb begin
        if (!enable)              hiz_mask_o = '0;
        else if (ctl.half_bridge) hiz_mask_o = half_mask;
        else                      hiz_mask_o = six_mask;
    end

    assign fault_o = |latched;

    a_r12_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hiz_en_i == 2'b00) |-> !fault_o);
    a_r3_all_six: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q_o[BIT_GROUPING] && enable && fault_o) |-> (hiz_mask_o == 6'h3F));
    a_r4_middle_pair_free: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q_o[BIT_GROUPING] |-> (hiz_mask_o[3:2] == 2'b00));
endmodule

// File: tb/test_hiz_shutdown_ctrl.sv
module test_hiz_shutdown_ctrl;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        string       req;
        logic [5:0]  mask;
        logic        fault;
        logic [15:0] mode;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_off = 2'b00;
    logic [1:0]  cmp = 2'b00;
    logic        period = 1'b0;
    logic        cancel = 1'b0;
    logic [1:0]  run = 2'b00;
    logic [1:0]  en = 2'b00;
    logic        wr = 1'b0;
    logic [15:0] wdata = 16'h0000;
    logic [15:0] mode_q;
    logic [5:0]  mask;
    logic        fault;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    exp_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiz_shutdown_ctrl i_hiz_shutdown_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_off_i      (ext_off),
        .cmp_i          (cmp),
        .period_pulse_i (period),
        .sw_cancel_i    (cancel),
        .chan_run_i     (run),
        .hiz_en_i       (en),
        .mode_wr_i      (wr),
        .mode_wdata_i   (wdata),
        .mode_q_o       (mode_q),
        .hiz_mask_o     (mask),
        .fault_o        (fault)
    );

    // Monitor: pop expected items and compare against the ports.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            n_vec++;
            if (mask !== cur.mask || fault !== cur.fault || mode_q !== cur.mode) begin
                n_bad++;
                $display("FAIL %s: mask=%h fault=%b mode=%h, expected mask=%h fault=%b mode=%h",
                         cur.req, mask, fault, mode_q, cur.mask, cur.fault, cur.mode);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_st(input string req, input logic [5:0] m,
                             input logic f, input logic [15:0] md);
        exp_t e;
        e.req = req; e.mask = m; e.fault = f; e.mode = md;
        sb.push_back(e);
        tick(2);
    endtask

    task automatic write_mode(input logic [15:0] d);
        wr = 1'b1; wdata = d;
        tick(1);
        wr = 1'b0;
        tick(1);
    endtask

    task automatic pulse_period();
        period = 1'b1; tick(1); period = 1'b0; tick(2);
    endtask

    task automatic pulse_cancel();
        cancel = 1'b1; tick(1); cancel = 1'b0; tick(2);
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        expect_st("R1 reset state", 6'h00, 1'b0, 16'h0000);

        // R2: writes blocked by running channel or nonzero enable.
        run = 2'b10; write_mode(16'h8000); run = 2'b00;
        expect_st("R2 blocked by run", 6'h00, 1'b0, 16'h0000);
        en = 2'b01; write_mode(16'h8000); en = 2'b00;
        expect_st("R2 blocked by enable", 6'h00, 1'b0, 16'h0000);

        // R13: low bits stored; six-phase, external, two-stage.
        write_mode(16'h0ABC);
        expect_st("R13 low bits readback", 6'h00, 1'b0, 16'h0ABC);
        en = 2'b01; tick(2);

        // R3/R6 source 0 automatic release; R10 waits for period.
        ext_off[0] = 1'b1; tick(5);
        expect_st("R3 six-phase all outputs", 6'h3F, 1'b1, 16'h0ABC);
        ext_off[0] = 1'b0; tick(5);
        expect_st("R10 held until period", 6'h3F, 1'b1, 16'h0ABC);
        pulse_period();
        expect_st("R6 src0 auto release", 6'h00, 1'b0, 16'h0ABC);

        // R11: re-activation before the boundary discards the release.
        ext_off[0] = 1'b1; tick(5);
        ext_off[0] = 1'b0; tick(5);
        ext_off[0] = 1'b1; tick(5);
        pulse_period();
        expect_st("R11 pending discarded", 6'h3F, 1'b1, 16'h0ABC);
        ext_off[0] = 1'b0; tick(5);
        pulse_period();
        expect_st("R11 later release", 6'h00, 1'b0, 16'h0ABC);

        // R6 source 1 needs cancel; R9 level held does not re-set.
        ext_off[1] = 1'b1; tick(5);
        ext_off[1] = 1'b0; tick(5);
        pulse_period();
        expect_st("R6 src1 not auto", 6'h3F, 1'b1, 16'h0ABC);
        ext_off[1] = 1'b1; tick(5);
        pulse_cancel();
        expect_st("R10 cancel alone not release", 6'h3F, 1'b1, 16'h0ABC);
        pulse_period();
        expect_st("R6 src1 cancel release", 6'h00, 1'b0, 16'h0ABC);
        tick(5);
        expect_st("R9 level no re-set", 6'h00, 1'b0, 16'h0ABC);
        ext_off[1] = 1'b0; tick(5);

        // R12: enable 00 clears latched state.
        ext_off[0] = 1'b1; tick(5);
        en = 2'b00; tick(1);
        expect_st("R12 mask off when disabled", 6'h00, 1'b0, 16'h0ABC);
        en = 2'b10; tick(3);
        expect_st("R12 state cleared", 6'h00, 1'b0, 16'h0ABC);
        ext_off[0] = 1'b0; tick(5);
        en = 2'b00; tick(2);

        // R5: comparator sources, external ignored.
        write_mode(16'h4000);
        en = 2'b01; tick(3);
        ext_off[0] = 1'b1; tick(5);
        expect_st("R5 external ignored", 6'h00, 1'b0, 16'h4000);
        ext_off[0] = 1'b0;
        cmp[0] = 1'b1; tick(5);
        expect_st("R5 comparator selected", 6'h3F, 1'b1, 16'h4000);
        cmp[0] = 1'b0; tick(5);
        pulse_period();
        expect_st("R5 comparator release", 6'h00, 1'b0, 16'h4000);
        en = 2'b00; tick(2);

        // R7: back-EMF mode, source 0 active low.
        cmp[0] = 1'b1; tick(4);
        write_mode(16'h5000);
        tick(4);
        en = 2'b11; tick(3);
        expect_st("R7 idle high inactive", 6'h00, 1'b0, 16'h5000);
        cmp[0] = 1'b0; tick(5);
        expect_st("R7 src0 low sets", 6'h3F, 1'b1, 16'h5000);
        cmp[0] = 1'b1; tick(5);
        pulse_period();
        expect_st("R7 src0 auto release", 6'h00, 1'b0, 16'h5000);
        cmp[1] = 1'b1; tick(5);
        expect_st("R7 src1 high sets", 6'h3F, 1'b1, 16'h5000);
        cmp[1] = 1'b0; tick(5);
        pulse_period();
        expect_st("R7 src1 auto release", 6'h00, 1'b0, 16'h5000);
        en = 2'b00; cmp = 2'b00; tick(4);

        // R4/R8: half-bridge, automatic release.
        write_mode(16'h8000);
        en = 2'b01; tick(3);
        ext_off[0] = 1'b1; tick(5);
        expect_st("R4 src0 pair", 6'h03, 1'b1, 16'h8000);
        ext_off[1] = 1'b1; tick(5);
        expect_st("R4 both pairs", 6'h33, 1'b1, 16'h8000);
        ext_off[0] = 1'b0; tick(5);
        pulse_period();
        expect_st("R8 auto release src0", 6'h30, 1'b1, 16'h8000);
        ext_off[1] = 1'b0; tick(5);
        pulse_period();
        expect_st("R8 auto release src1", 6'h00, 1'b0, 16'h8000);
        en = 2'b00; tick(2);

        // R8: half-bridge, software release.
        write_mode(16'hA000);
        en = 2'b01; tick(3);
        ext_off[0] = 1'b1; tick(5);
        ext_off[0] = 1'b0; tick(5);
        pulse_period();
        expect_st("R8 sw mode no auto", 6'h03, 1'b1, 16'hA000);
        pulse_cancel();
        pulse_period();
        expect_st("R8 sw release", 6'h00, 1'b0, 16'hA000);

        tick(3);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule